// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation converter. Software sets a busy bit to request a conversion. The block may then keep the sample switch closed for a programmable number of conversion-clock periods of automatic acquisition. After that it opens the switch and spends one setup period in hold. It then resolves the result one bit per conversion-clock period, starting with the most significant bit. For each bit it drives a trial code to the DAC and reads back one comparator bit. At the end it stores the result, raises a sticky interrupt flag and releases the busy bit. Every operation, whether it completed or was aborted, is followed by a two-period discharge phase. Acquisition then resumes with the switch closed.

The conversion clock is a one-cycle enable pulse. A divider produces it from the system clock, with a programmable period of `div_i + 1` cycles. The analog parts (sample switch, capacitor array and comparator) sit outside the block. Software may abort a conversion by clearing the busy bit, and the stored result is then left untouched. Software may also write the result register directly, but only while the block is idle.

The state machine has five states. IDLE goes to ACQ when a request arrives with a non-zero acquisition select, and to HOLD when the select is zero. ACQ goes to HOLD after the selected tick count. HOLD goes to CONV after one tick. CONV goes to DISCH when the last bit is resolved. ACQ, HOLD and CONV all go to DISCH on an abort. DISCH goes back to IDLE after two ticks.

Top module: `adc_sar_sequencer`

## Requirements
- R1: After reset, busy_o, flag_o, discharge_o, dac_code_o and result_o are all 0 and sample_o is 1.
- R2: A go_set_i pulse sets busy_o on the next clock only if en_i was already 1 in the previous cycle. A pulse in the same cycle that en_i first rises leaves busy_o at 0.
- R3: With acq_sel_i = 0 the block skips acquisition. sample_o falls one clock after busy_o becomes visible.
- R4: The acquisition select codes 1 to 7 give 2, 4, 6, 8, 12, 16 and 20 ticks of acquisition with sample_o held at 1. With div_i = 0, sample_o falls N+1 clocks after busy_o becomes visible, where N is that tick count.
- R5: sample_o stays 0 for one setup tick plus 10 bit ticks. The first trial code is 512. For each bit the trial bit is kept when cmp_i = 1 (input at or above the trial code) and dropped otherwise, working from bit 9 down to bit 0.
- R6: In the clock where bit 0 is resolved, result_o takes the 10-bit value right-justified with bits 15:10 zero. In the same clock busy_o clears, flag_o sets and sample_o returns to 1.
- R7: Clearing busy with go_clr_i during acquisition, hold or conversion aborts the operation. result_o and flag_o keep their values, and the block enters discharge.
- R8: Discharge lasts exactly 2 ticks, with discharge_o = 1 and sample_o = 1. Its length is 2(div_i + 1) clocks after a completion.
- R9: flag_o stays set until flag_clr_i is pulsed. If a set and a clear arrive together, the set wins.
- R10: A write with res_wr_i updates result_o on the next clock only in IDLE with busy_o = 0. A write at any other time is ignored.
- R11: The conversion clock ticks once every div_i + 1 system clocks. With div_i = d, the sample-open window lasts between 10(d+1)+1 and 11(d+1) clocks.
- R12: go_clr_i takes priority over go_set_i. Dropping en_i during an operation aborts it in the same way as go_clr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Converter enable |
| go_set_i | input | 1 | Software pulse that sets the busy bit |
| go_clr_i | input | 1 | Software pulse that clears the busy bit (abort) |
| acq_sel_i | input | 3 | Acquisition-time select |
| div_i | input | 4 | Conversion-clock divider; period is div_i+1 clocks |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the trial code |
| res_wr_i | input | 1 | Software write strobe for the result register |
| res_wdata_i | input | 16 | Software write data |
| flag_clr_i | input | 1 | Software pulse that clears the interrupt flag |
| busy_o | output | 1 | Busy bit |
| sample_o | output | 1 | Sample switch closed |
| discharge_o | output | 1 | Capacitor-array discharge active |
| dac_code_o | output | 10 | Trial code to the DAC (0 outside conversion) |
| result_o | output | 16 | Result register, right-justified |
| flag_o | output | 1 | Sticky conversion-complete flag |

## Verification
The bench models an ideal comparator and sweeps every 10-bit input level. A wrong bit order or an inverted keep/drop decision shows up as a wrong stored code.

It measures, in clocks, the acquisition window for every select code, the sample-open window and the discharge length at several divider settings. An off-by-one phase counter, or a divider that ticks once too often, changes these lengths.

Aborts from both go_clr_i and a drop of en_i are checked, including a result write attempted in the middle of a conversion. A design that loaded a partial result or accepted that write would change result_o. Set and clear of busy in the same cycle, and a start issued together with enable, are also covered. A design with the wrong priority or the wrong enable gating would launch a conversion in those cases.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ,
        ST_HOLD,
        ST_CONV,
        ST_DISCH
    } seq_state_e;

    // acquisition length in conversion-clock ticks per select code
    function automatic logic [4:0] acq_ticks(input logic [2:0] sel);
        logic [4:0] n;
        unique case (sel)
            3'd0: n = 5'd0;
            3'd1: n = 5'd2;
            3'd2: n = 5'd4;
            3'd3: n = 5'd6;
            3'd4: n = 5'd8;
            3'd5: n = 5'd12;
            3'd6: n = 5'd16;
            default: n = 5'd20;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/adc_tick_div.sv
module adc_tick_div #(
    parameter int DIVW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIVW-1:0] div_i,
    output logic            tick_o
);

    logic [DIVW-1:0] cnt_q;

    assign tick_o = (cnt_q >= div_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // R11: two ticks are never adjacent unless the divider is zero
    p_tick_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));

endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         init_i,
    input  logic         step_i,
    input  logic         cmp_i,
    output logic [W-1:0] code_o,
    output logic [W-1:0] resolved_o,
    output logic         last_o
);

    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] code_q;
    logic [W-1:0] mask_q;

    assign code_o     = code_q;
    assign last_o     = mask_q[0];
    assign resolved_o = cmp_i ? code_q : (code_q & ~mask_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            mask_q <= '0;
        end else if (clr_i) begin
            code_q <= '0;
            mask_q <= '0;
        end else if (init_i) begin
            code_q <= TOP_BIT;
            mask_q <= TOP_BIT;
        end else if (step_i) begin
            code_q <= resolved_o | (mask_q >> 1);
            mask_q <= mask_q >> 1;
        end
    end

    // R5: at most one trial bit is under test at any time
    p_mask_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_q));

endmodule

// File: rtl/adc_sar_sequencer.sv
module adc_sar_sequencer
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int REG_W = 16,
    parameter int DIVW  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             go_set_i,
    input  logic             go_clr_i,
    input  logic [2:0]       acq_sel_i,
    input  logic [DIVW-1:0]  div_i,
    input  logic             cmp_i,
    input  logic             res_wr_i,
    input  logic [REG_W-1:0] res_wdata_i,
    input  logic             flag_clr_i,
    output logic             busy_o,
    output logic             sample_o,
    output logic             discharge_o,
    output logic [RES_W-1:0] dac_code_o,
    output logic [REG_W-1:0] result_o,
    output logic             flag_o
);

    localparam int          PHW       = 5;
    localparam logic [PHW-1:0] DIS_TICKS = PHW'(2);

    seq_state_e     state_q, state_d;
    logic [PHW-1:0] ph_cnt_q;
    logic [4:0]     acq_n_q;
    logic           busy_q, en_q, flag_q;
    logic [REG_W-1:0] result_q;

    logic             tick;
    logic [RES_W-1:0] sar_code, sar_resolved;
    logic             sar_last;
    logic             active, abort, done;
    logic             sar_clr, sar_init, sar_step;

    adc_tick_div #(.DIVW(DIVW)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (div_i),
        .tick_o (tick)
    );

    adc_sar_reg #(.W(RES_W)) u_sar (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (sar_clr),
        .init_i     (sar_init),
        .step_i     (sar_step),
        .cmp_i      (cmp_i),
        .code_o     (sar_code),
        .resolved_o (sar_resolved),
        .last_o     (sar_last)
    );

    assign active = (state_q == ST_ACQ) || (state_q == ST_HOLD) || (state_q == ST_CONV);
    assign abort  = active && (go_clr_i || !en_i);
    assign done   = (state_q == ST_CONV) && tick && sar_last && !abort;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (busy_q && en_i && !go_clr_i)
                    state_d = (acq_ticks(acq_sel_i) == 5'd0) ? ST_HOLD : ST_ACQ;
            end
            ST_ACQ: begin
                if (abort)                                        state_d = ST_DISCH;
                else if (tick && ph_cnt_q == PHW'(acq_n_q - 5'd1)) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (abort)     state_d = ST_DISCH;
                else if (tick) state_d = ST_CONV;
            end
            ST_CONV: begin
                if (abort)                 state_d = ST_DISCH;
                else if (tick && sar_last) state_d = ST_DISCH;
            end
            ST_DISCH: begin
                if (tick && ph_cnt_q == DIS_TICKS - 1'b1) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ph_cnt_q <= '0;
            acq_n_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) ph_cnt_q <= '0;
            else if (tick)          ph_cnt_q <= ph_cnt_q + 1'b1;
            if (state_q == ST_IDLE) acq_n_q <= acq_ticks(acq_sel_i);
        end
    end

    // software-visible registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            busy_q   <= 1'b0;
            flag_q   <= 1'b0;
            result_q <= '0;
        end else begin
            en_q <= en_i;
            if (go_clr_i || !en_i || done)   busy_q <= 1'b0;
            else if (go_set_i && en_q)       busy_q <= 1'b1;
            if (done)            flag_q <= 1'b1;
            else if (flag_clr_i) flag_q <= 1'b0;
            if (done)
                result_q <= {{(REG_W-RES_W){1'b0}}, sar_resolved};
            else if (res_wr_i && state_q == ST_IDLE && !busy_q)
                result_q <= res_wdata_i;
        end
    end

    // outputs and datapath controls
    always_comb begin
        sar_clr     = (state_q == ST_IDLE) || (state_q == ST_DISCH);
        sar_init    = (state_q == ST_HOLD) && tick && !abort;
        sar_step    = (state_q == ST_CONV) && tick && !abort;
        sample_o    = !((state_q == ST_HOLD) || (state_q == ST_CONV));
        discharge_o = (state_q == ST_DISCH);
        dac_code_o  = (state_q == ST_CONV) ? sar_code : '0;
        busy_o      = busy_q;
        flag_o      = flag_q;
        result_o    = result_q;
    end

    // R2: a start without prior enable does not set busy
    p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (go_set_i && !en_q && !busy_q) |=> !busy_o);

    // R6: a completed conversion leaves busy low and the flag high
    p_done_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && state_d == ST_DISCH && !go_clr_i && en_i)
            |=> (flag_o && !busy_o && sample_o));

    // R7: an abort does not touch the result
    p_abort_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && go_clr_i) |=> $stable(result_o));

    // R10: the result changes only on completion or an idle write
    p_result_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> ($past(state_q) == ST_CONV || $past(state_q) == ST_IDLE));

    // R8: discharge never runs past its tick count
    p_disch_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DISCH) |-> (ph_cnt_q < DIS_TICKS));

    // R5: a trial code is always presented during conversion
    p_dac_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV) |-> (dac_code_o != '0));

endmodule

// File: tb/adc_sar_sequencer_tb.sv
module adc_sar_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic        go_set_i = 1'b0;
    logic        go_clr_i = 1'b0;
    logic [2:0]  acq_sel_i = 3'd0;
    logic [3:0]  div_i = 4'd0;
    logic        cmp_i;
    logic        res_wr_i = 1'b0;
    logic [15:0] res_wdata_i = 16'd0;
    logic        flag_clr_i = 1'b0;
    logic        busy_o, sample_o, discharge_o, flag_o;
    logic [9:0]  dac_code_o;
    logic [15:0] result_o;
    logic [9:0]  vin = 10'd0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    // ideal comparator
    assign cmp_i = (vin >= dac_code_o);

    adc_sar_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .go_set_i(go_set_i),
        .go_clr_i(go_clr_i), .acq_sel_i(acq_sel_i), .div_i(div_i),
        .cmp_i(cmp_i), .res_wr_i(res_wr_i), .res_wdata_i(res_wdata_i),
        .flag_clr_i(flag_clr_i), .busy_o(busy_o), .sample_o(sample_o),
        .discharge_o(discharge_o), .dac_code_o(dac_code_o),
        .result_o(result_o), .flag_o(flag_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            finish_run();
        end
    end

    function automatic int acq_len(input int sel);
        case (sel)
            0: return 0;  1: return 2;  2: return 4;  3: return 6;
            4: return 8;  5: return 12; 6: return 16; default: return 20;
        endcase
    endfunction

    task automatic pulse_start();
        go_set_i = 1'b1;
        @(negedge clk);
        go_set_i = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr_i = 1'b1;
        @(negedge clk);
        flag_clr_i = 1'b0;
    endtask

    // full conversion; exact timing checks only when exact is set
    task automatic run_conv(input int v, input int acq, input int dv, input bit exact);
        int c, l, d;
        vin = 10'(v); acq_sel_i = 3'(acq); div_i = 4'(dv);
        pulse_start();
        c = 0; l = 0; d = 0;
        while (sample_o) begin @(negedge clk); c++; end
        while (!sample_o) begin @(negedge clk); l++; end
        chk(result_o == 16'(v), "R5 result", int'(result_o), v);
        chk(flag_o && !busy_o, "R6 flag/busy at completion", {flag_o, busy_o}, 2);
        while (discharge_o) begin @(negedge clk); d++; end
        chk(d == 2 * (dv + 1), "R8 discharge length", d, 2 * (dv + 1));
        if (exact) begin
            chk(c == acq_len(acq) + 1, (acq == 0) ? "R3 acq skip" : "R4 acq length",
                c, acq_len(acq) + 1);
            chk(l == 11, "R5 sample-open length", l, 11);
        end else begin
            chk(l >= 10 * (dv + 1) + 1 && l <= 11 * (dv + 1), "R11 divided open window",
                l, 11 * (dv + 1));
        end
        clear_flag();
    endtask

    initial begin
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy_o && !flag_o && !discharge_o && sample_o, "R1 control outputs",
            {busy_o, flag_o, discharge_o, sample_o}, 1);
        chk(result_o == 16'd0 && dac_code_o == 10'd0, "R1 data outputs",
            int'(result_o), 0);

        // R2 start together with enable is ignored
        en_i = 1'b1; go_set_i = 1'b1;
        @(negedge clk);
        go_set_i = 1'b0;
        chk(!busy_o, "R2 start with enable ignored", busy_o, 0);
        repeat (2) @(negedge clk);
        chk(sample_o && !busy_o, "R2 no conversion launched", busy_o, 0);

        // R12 set and clear together: clear wins
        go_set_i = 1'b1; go_clr_i = 1'b1;
        @(negedge clk);
        go_set_i = 1'b0; go_clr_i = 1'b0;
        chk(!busy_o, "R12 clear beats set", busy_o, 0);

        // R2 start when already enabled
        vin = 10'd777;
        pulse_start();
        chk(busy_o, "R2 start accepted", busy_o, 1);
        @(negedge clk);   // HOLD
        @(negedge clk);   // first CONV cycle
        chk(dac_code_o == 10'd512, "R5 first trial code", int'(dac_code_o), 512);
        while (!sample_o) @(negedge clk);
        chk(result_o == 16'd777, "R6 result loaded", int'(result_o), 777);
        while (discharge_o) @(negedge clk);
        // R9 sticky flag
        repeat (5) @(negedge clk);
        chk(flag_o, "R9 flag sticky", flag_o, 1);
        clear_flag();
        chk(!flag_o, "R9 flag cleared", flag_o, 0);

        // R5 sweep of all input levels
        for (int v = 0; v < 1024; v++) run_conv(v, 0, 0, (v % 64) == 0);

        // R4 every acquisition select
        for (int a = 0; a < 8; a++) run_conv(300 + a, a, 0, 1'b1);

        // R11 divided conversion clock
        for (int dv = 1; dv < 4; dv++) begin
            run_conv(1023, dv, dv, 1'b0);
            run_conv(0, 0, dv, 1'b0);
            run_conv(341 * dv, 7, dv, 1'b0);
        end

        // R7 abort by clear, with R10 write attempt mid-conversion
        run_conv(99, 0, 0, 1'b1);
        vin = 10'd600;
        pulse_start();
        repeat (4) @(negedge clk);
        chk(!sample_o, "R7 in conversion", sample_o, 0);
        res_wr_i = 1'b1; res_wdata_i = 16'hABCD;
        @(negedge clk);
        res_wr_i = 1'b0;
        go_clr_i = 1'b1;
        @(negedge clk);
        go_clr_i = 1'b0;
        chk(!busy_o && discharge_o && sample_o, "R7 abort enters discharge",
            {busy_o, discharge_o, sample_o}, 3);
        w = 0;
        while (discharge_o) begin @(negedge clk); w++; end
        chk(w == 2, "R8 discharge after abort", w, 2);
        chk(result_o == 16'd99, "R7/R10 result untouched", int'(result_o), 99);
        chk(!flag_o, "R7 flag untouched", flag_o, 0);

        // R10 idle write accepted
        res_wr_i = 1'b1; res_wdata_i = 16'h0155;
        @(negedge clk);
        res_wr_i = 1'b0;
        chk(result_o == 16'h0155, "R10 idle write", int'(result_o), 16'h0155);

        // R12 enable drop aborts
        vin = 10'd5; acq_sel_i = 3'd2;
        pulse_start();
        repeat (3) @(negedge clk);
        en_i = 1'b0;
        @(negedge clk);
        chk(!busy_o && discharge_o, "R12 enable drop aborts", {busy_o, discharge_o}, 1);
        while (discharge_o) @(negedge clk);
        chk(result_o == 16'h0155 && !flag_o, "R12 result kept", int'(result_o), 16'h0155);

        finish_run();
    end

endmodule